// File: doc/BRIEF.md
# MMC Command Line Engine

This block drives the bidirectional command line of a MultiMediaCard host. Software loads five command bytes into a transmit byte queue: one index byte and four argument bytes. It then pulses the launch control. The engine serialises a 48-bit command one bit per clock, most significant bit first. It forces the framing bits and appends a CRC7 that it computes on the fly.

When a response has been armed beforehand, the engine releases the line after the command. It then waits a bounded time for the card's start bit. It captures either a short (48-bit) or a long (136-bit) response. The received bits are packed into bytes, most significant bit first, and pushed into a receive byte queue. The engine checks the response CRC7 unless checking is disabled. It raises a one-cycle done pulse that a data sequencer can use to start a deferred data phase. Card clock generation and the data lines are outside this block.

Both byte queues use valid/ready streams. A byte is accepted on `in_*` in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low while the queue is full or held in reset. A byte leaves on `out_*` in a cycle where `out_valid` and `out_ready` are both high, and `out_data` holds steady while `out_ready` is low. The card cannot be stalled, so response bytes that arrive while the receive queue is full are dropped.

Top module: `mmc_cmd_engine`

## Requirements
- R1: A falling edge of `cmd_en` (high in one cycle, low in the next) launches a command only when the engine is idle and at least 5 bytes are queued; otherwise it is ignored and `cmd_oe` stays low.
- R2: A command is 48 bits with `cmd_oe` high for exactly 48 consecutive cycles, in this order: bit 0 is 0, bit 1 is 1, bits 2..7 are bits 5..0 of the first queued byte (its top two bits are ignored), bits 8..39 are the next four queued bytes MSB first, bits 40..46 are the CRC7, and bit 47 is 1.
- R3: The command CRC7 uses polynomial x^7+x^3+1, starts from zero, covers bits 0..39, and is sent MSB first.
- R4: A falling edge of `resp_en` arms a response. After an armed command, the line is released and `cmd_in` is sampled for a 0 start bit for up to 64 cycles. If no start bit arrives, `resp_timeout` is set, the engine returns idle, and `resp_done` does not pulse.
- R5: With `resp_fmt48`=1 at launch the response is 48 bits (6 bytes). With `resp_fmt48`=0 it is 136 bits (17 bytes). All bits starting with the start bit are packed MSB first into `out_data` bytes, in arrival order.
- R6: The response CRC7 covers bits 0..39 and is compared with bits 40..46 for a 48-bit response. For a 136-bit response it covers bits 8..127 and is compared with bits 128..134. Any mismatch sets `crc_err`.
- R7: With `crc_dis`=1 at launch, `crc_err` stays 0 whatever CRC bits are received.
- R8: After the last response bit is sampled, `resp_done` is high for exactly one cycle, and `resp_ok` is high from then on.
- R9: While `tx_ptr_rst` is high the transmit queue is emptied and `in_ready` is low. Bytes queued before it are gone after release.
- R10: While `rx_ptr_rst` is high the receive queue is emptied and `out_valid` is low. It stays empty after release until new response bytes arrive.
- R11: Without an armed response the engine returns idle after the 48th bit. It captures no bytes and does not pulse `resp_done`.
- R12: After reset `cmd_oe`=0, `cmd_out`=1, `busy`=0, all status outputs are 0, `in_ready`=1 and `out_valid`=0. A launch clears `resp_ok`, `crc_err` and `resp_timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_en | input | 1 | Launch control, acts on its falling edge |
| resp_en | input | 1 | Response arm control, acts on its falling edge |
| resp_fmt48 | input | 1 | 1 selects a 48-bit response, 0 selects 136-bit |
| crc_dis | input | 1 | 1 bypasses the response CRC7 check |
| tx_ptr_rst | input | 1 | Holds the transmit queue empty |
| rx_ptr_rst | input | 1 | Holds the receive queue empty |
| in_valid | input | 1 | Command byte valid |
| in_ready | output | 1 | Transmit queue accepts a byte |
| in_data | input | 8 | Command byte |
| out_valid | output | 1 | Response byte valid |
| out_ready | input | 1 | Consumer takes the response byte |
| out_data | output | 8 | Response byte |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Sampled command line |
| busy | output | 1 | Engine not idle |
| resp_ok | output | 1 | Response received |
| crc_err | output | 1 | Response CRC7 mismatch |
| resp_timeout | output | 1 | No start bit within the wait window |
| resp_done | output | 1 | One-cycle pulse at the end of a response |

## Verification
The hardest case to reach from the ports is a response whose CRC field disagrees with its payload. This matters most in the long format, where the header byte must stay out of the CRC. A card model that always answers correctly never produces it. The bench builds every response itself, computes the CRC over the correct bit window with its own function, and then flips a single CRC bit for the faulty cases. It drives the line bit by bit only after it sees the output enable drop. A separate case leaves the line high to force the wait window to expire.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV
  } eng_state_t;

  localparam int CMD_BITS   = 48;
  localparam int CMD_BYTES  = 5;
  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;

  // one step of the x^7+x^3+1 shift register, input bit fed at the top
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic d);
    logic fb;
    fb = d ^ c[6];
    crc7_step = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

endpackage

// File: rtl/mmc_byte_fifo.sv
module mmc_byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic [$clog2(DEPTH):0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      cnt;
  logic             push, pop;

  assign in_ready  = !clr && (cnt != FULL_LVL);
  assign out_valid = !clr && (cnt != '0);
  assign out_data  = mem[rd_ptr];
  assign level     = cnt;
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

endmodule

// File: rtl/mmc_fall_detect.sv
module mmc_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fell
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign fell = lvl_q && !lvl;

endmodule

// File: rtl/mmc_cmd_engine.sv
module mmc_cmd_engine
  import mmc_cmd_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 32,
  parameter int TIMEOUT  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_en,
  input  logic       resp_en,
  input  logic       resp_fmt48,
  input  logic       crc_dis,
  input  logic       tx_ptr_rst,
  input  logic       rx_ptr_rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       cmd_out,
  output logic       cmd_oe,
  input  logic       cmd_in,
  output logic       busy,
  output logic       resp_ok,
  output logic       crc_err,
  output logic       resp_timeout,
  output logic       resp_done
);
  localparam int TXL = $clog2(TX_DEPTH) + 1;
  localparam int RXL = $clog2(RX_DEPTH) + 1;
  localparam int TW  = $clog2(TIMEOUT + 1);
  localparam logic [TXL-1:0] NEED_BYTES = TXL'(CMD_BYTES);
  localparam logic [7:0] DATA_END  = 8'(CMD_BYTES * 8);
  localparam logic [7:0] CMD_LAST  = 8'(CMD_BITS - 1);
  localparam logic [7:0] S_LAST    = 8'(SHORT_BITS - 1);
  localparam logic [7:0] L_LAST    = 8'(LONG_BITS - 1);
  localparam logic [7:0] S_CRC_AT  = 8'(SHORT_BITS - 8);
  localparam logic [7:0] L_CRC_AT  = 8'(LONG_BITS - 8);
  localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT - 1);

  eng_state_t    state;
  logic [7:0]    bit_cnt;
  logic [TW-1:0] tmo_cnt;
  logic [7:0]    cur;
  logic [6:0]    sh;
  logic [6:0]    crc;
  logic          mism, armed, fmt48_q, dis_q;

  logic           cmd_fell, resp_fell, launch;
  logic [TXL-1:0] tx_level;
  logic [7:0]     tx_head;
  logic           tx_valid, tx_pop;
  logic           rx_push, rx_in_ready;
  logic [RXL-1:0] rx_level;
  logic [7:0]     rx_byte;
  logic           nxt_bit;
  logic [7:0]     crc_idx, resp_last, crc_at, data_lo;
  logic           in_data_zone, in_crc_zone, exp_bit;
  logic           unused_rx;

  mmc_fall_detect u_launch_edge (.clk(clk), .rst_n(rst_n), .lvl(cmd_en),  .fell(cmd_fell));
  mmc_fall_detect u_arm_edge    (.clk(clk), .rst_n(rst_n), .lvl(resp_en), .fell(resp_fell));

  mmc_byte_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_ptr_rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(tx_valid), .out_ready(tx_pop), .out_data(tx_head),
    .level(tx_level)
  );

  mmc_byte_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_ptr_rst),
    .in_valid(rx_push), .in_ready(rx_in_ready), .in_data(rx_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .level(rx_level)
  );

  assign unused_rx = &{1'b0, rx_in_ready, rx_level, tx_valid};

  assign launch = cmd_fell && (state == ST_IDLE) && (tx_level >= NEED_BYTES);
  assign busy   = (state != ST_IDLE);

  // transmit bit selection: a byte is taken from the queue head at each byte boundary
  always_comb begin
    tx_pop  = 1'b0;
    nxt_bit = 1'b1;
    crc_idx = 8'd46 - bit_cnt;
    if (state == ST_SEND) begin
      if (bit_cnt < DATA_END) begin
        if (bit_cnt[2:0] == 3'd0) begin
          nxt_bit = tx_head[7];
          tx_pop  = 1'b1;
        end else begin
          nxt_bit = cur[3'd7 - bit_cnt[2:0]];
        end
        if (bit_cnt == 8'd0) nxt_bit = 1'b0;
        if (bit_cnt == 8'd1) nxt_bit = 1'b1;
      end else if (bit_cnt < CMD_LAST) begin
        nxt_bit = crc[crc_idx[2:0]];
      end
    end
  end

  // receive windows depend on the latched format
  always_comb begin
    resp_last    = fmt48_q ? S_LAST   : L_LAST;
    crc_at       = fmt48_q ? S_CRC_AT : L_CRC_AT;
    data_lo      = fmt48_q ? 8'd0     : 8'd8;
    in_data_zone = (bit_cnt >= data_lo) && (bit_cnt < crc_at);
    in_crc_zone  = (bit_cnt >= crc_at) && (bit_cnt < crc_at + 8'd7);
    exp_bit      = crc[3'(crc_at + 8'd6 - bit_cnt)];
    rx_push      = (state == ST_RECV) && (bit_cnt[2:0] == 3'd7);
    rx_byte      = {sh, cmd_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      bit_cnt      <= '0;
      tmo_cnt      <= '0;
      cur          <= '0;
      sh           <= '0;
      crc          <= '0;
      mism         <= 1'b0;
      armed        <= 1'b0;
      fmt48_q      <= 1'b1;
      dis_q        <= 1'b0;
      cmd_out      <= 1'b1;
      cmd_oe       <= 1'b0;
      resp_ok      <= 1'b0;
      crc_err      <= 1'b0;
      resp_timeout <= 1'b0;
      resp_done    <= 1'b0;
    end else begin
      resp_done <= 1'b0;
      if (resp_fell) armed <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          cmd_oe  <= 1'b0;
          cmd_out <= 1'b1;
          if (launch) begin
            state        <= ST_SEND;
            bit_cnt      <= '0;
            crc          <= '0;
            fmt48_q      <= resp_fmt48;
            dis_q        <= crc_dis;
            resp_ok      <= 1'b0;
            crc_err      <= 1'b0;
            resp_timeout <= 1'b0;
          end
        end
        ST_SEND: begin
          cmd_oe  <= 1'b1;
          cmd_out <= nxt_bit;
          if (tx_pop) cur <= tx_head;
          if (bit_cnt < DATA_END) crc <= crc7_step(crc, nxt_bit);
          if (bit_cnt == CMD_LAST) begin
            bit_cnt <= '0;
            tmo_cnt <= '0;
            if (armed) begin
              state <= ST_WAIT;
              armed <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            bit_cnt <= bit_cnt + 8'd1;
          end
        end
        ST_WAIT: begin
          cmd_oe  <= 1'b0;
          cmd_out <= 1'b1;
          if (!cmd_in) begin
            state   <= ST_RECV;
            bit_cnt <= 8'd1;
            sh      <= {sh[5:0], 1'b0};
            crc     <= '0;
            mism    <= 1'b0;
          end else if (tmo_cnt == TMO_LAST) begin
            state        <= ST_IDLE;
            resp_timeout <= 1'b1;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        ST_RECV: begin
          sh <= {sh[5:0], cmd_in};
          if (in_data_zone) crc <= crc7_step(crc, cmd_in);
          if (in_crc_zone && (cmd_in != exp_bit)) mism <= 1'b1;
          if (bit_cnt == resp_last) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            resp_done <= 1'b1;
            resp_ok   <= 1'b1;
            crc_err   <= !dis_q && mism;
          end else begin
            bit_cnt <= bit_cnt + 8'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

module mmc_cmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_oe,
  input logic cmd_out,
  input logic resp_done,
  input logic resp_ok,
  input logic resp_timeout,
  input logic busy,
  input logic rx_ptr_rst,
  input logic out_valid
);
  logic [7:0] oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      oe_run <= '0;
    else if (cmd_oe) oe_run <= oe_run + 8'd1;
    else             oe_run <= '0;
  end

  assert_oe_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_oe) |-> (oe_run == 8'd48));

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_out);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);

  assert_done_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |-> (resp_ok && !resp_timeout));

  assert_timeout_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_timeout) |-> (!busy && !resp_done));

  assert_rx_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ptr_rst |=> !out_valid);

endmodule

bind mmc_cmd_engine mmc_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_oe(cmd_oe), .cmd_out(cmd_out),
  .resp_done(resp_done), .resp_ok(resp_ok), .resp_timeout(resp_timeout),
  .busy(busy), .rx_ptr_rst(rx_ptr_rst), .out_valid(out_valid)
);

// File: tb/test_mmc_cmd_engine.sv
module test_mmc_cmd_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_en = 0, resp_en = 0, resp_fmt48 = 1, crc_dis = 0;
  logic tx_ptr_rst = 0, rx_ptr_rst = 0;
  logic in_valid = 0, out_ready = 0, cmd_in = 1;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, cmd_out, cmd_oe, busy, resp_ok, crc_err, resp_timeout, resp_done;
  logic [7:0] out_data;

  int checks = 0, errors = 0, done_cnt = 0;

  always #5 clk = ~clk;

  mmc_cmd_engine i_mmc_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .resp_en(resp_en),
    .resp_fmt48(resp_fmt48), .crc_dis(crc_dis), .tx_ptr_rst(tx_ptr_rst),
    .rx_ptr_rst(rx_ptr_rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in),
    .busy(busy), .resp_ok(resp_ok), .crc_err(crc_err),
    .resp_timeout(resp_timeout), .resp_done(resp_done)
  );

  always @(negedge clk) if (rst_n && resp_done) done_cnt++;

  // fields: idx[42:37] arg[36:5] armed[4] fmt48[3] dis[2] kind[1:0]
  // kind: 0 no response, 1 good, 2 bad CRC, 3 silent line
  localparam logic [42:0] VEC [0:5] = '{
    {6'h11, 32'h12345678, 1'b1, 1'b1, 1'b0, 2'd1},
    {6'h02, 32'hDEADBEEF, 1'b1, 1'b0, 1'b0, 2'd1},
    {6'h3F, 32'h00000000, 1'b1, 1'b1, 1'b0, 2'd2},
    {6'h09, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b1, 2'd2},
    {6'h00, 32'h0000FFFF, 1'b0, 1'b1, 1'b0, 2'd0},
    {6'h2A, 32'h80000001, 1'b1, 1'b1, 1'b0, 2'd3}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [135:0] v, input int n,
                                         input int first, input int last);
    logic [6:0] c = '0;
    for (int p = first; p <= last; p++) begin
      logic fb;
      fb = v[n-1-p] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_launch();
    @(negedge clk); cmd_en = 1'b1;
    @(negedge clk); cmd_en = 1'b0;
  endtask

  task automatic pulse_arm();
    @(negedge clk); resp_en = 1'b1;
    @(negedge clk); resp_en = 1'b0;
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk({tag, " byte valid"}, 64'(out_valid), 64'd1);
    chk({tag, " byte value"}, 64'(out_data), 64'(exp));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic expect_no_launch(input string tag);
    logic seen = 1'b0;
    for (int w = 0; w < 12; w++) begin
      @(negedge clk);
      if (cmd_oe || busy) seen = 1'b1;
    end
    chk(tag, 64'(seen), 64'd0);
  endtask

  task automatic run_case(input logic [42:0] v, input bit do_pop);
    logic [5:0] idx; logic [31:0] arg; logic armed, f48, dis; logic [1:0] kind;
    logic [47:0] frame, got; logic [135:0] r; int n, w, nb, base;
    {idx, arg, armed, f48, dis, kind} = v;
    frame = {1'b0, 1'b1, idx, arg, 7'h00, 1'b1};
    frame[7:1] = ref_crc({88'h0, frame}, 48, 0, 39);
    if (f48) begin
      n = 48;
      r = {88'h0, 1'b0, 1'b0, idx, arg, 7'h00, 1'b1};
      r[7:1] = ref_crc(r, 48, 0, 39);
    end else begin
      n = 136;
      r = {8'h3F, arg, ~arg, arg ^ 32'hA5A5A5A5, arg[23:0], 7'h00, 1'b1};
      r[7:1] = ref_crc(r, 136, 8, 127);
    end
    if (kind == 2'd2) r[1] = ~r[1];
    resp_fmt48 = f48;
    crc_dis    = dis;
    push_byte({2'b10, idx});
    for (int i = 3; i >= 0; i--) push_byte(arg[i*8 +: 8]);
    if (armed) pulse_arm();
    pulse_launch();
    w = 0;
    while (!cmd_oe && w < 10) begin @(negedge clk); w++; end
    chk("R12 status cleared by launch", 64'({resp_ok, crc_err, resp_timeout}), 64'd0);
    n = (f48 ? 48 : 136);
    w = 0; got = '0;
    while (cmd_oe && w < 60) begin got = {got[46:0], cmd_out}; w++; @(negedge clk); end
    chk("R2 command length", 64'(w), 64'd48);
    chk("R2 R3 command frame", 64'(got), 64'(frame));
    base = done_cnt;
    if (kind == 2'd0 || kind == 2'd3) begin
      repeat (80) @(negedge clk);
      if (kind == 2'd0) begin
        chk("R11 no capture", 64'({out_valid, resp_ok, resp_timeout, busy}), 64'd0);
        chk("R11 no done pulse", 64'(done_cnt), 64'(base));
      end else begin
        chk("R4 timeout flagged", 64'({resp_timeout, resp_ok, busy}), 64'b100);
        chk("R4 no done pulse", 64'(done_cnt), 64'(base));
      end
    end else begin
      repeat (2) @(negedge clk);
      for (int p = 0; p < n; p++) begin cmd_in = r[n-1-p]; @(negedge clk); end
      cmd_in = 1'b1;
      @(negedge clk);
      chk("R8 single done pulse", 64'(done_cnt), 64'(base + 1));
      chk("R8 resp_ok", 64'({resp_ok, resp_timeout, resp_done}), 64'b100);
      chk((dis ? "R7 crc bypass" : "R6 crc check"), 64'(crc_err),
          64'((kind == 2'd2) && !dis));
      if (do_pop) begin
        nb = n / 8;
        for (int i = 0; i < nb; i++) pop_chk(r[n-1-8*i -: 8], "R5");
        @(negedge clk);
        chk("R5 byte count", 64'(out_valid), 64'd0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset line", 64'({cmd_oe, cmd_out, busy}), 64'b010);
    chk("R12 reset status", 64'({resp_ok, crc_err, resp_timeout, resp_done}), 64'd0);
    chk("R12 reset streams", 64'({in_ready, out_valid}), 64'b10);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: too few bytes queued
    for (int i = 0; i < 3; i++) push_byte(8'h40 + 8'(i));
    pulse_launch();
    expect_no_launch("R1 launch ignored with 3 bytes");

    // R9: pointer reset drops the queued bytes
    @(negedge clk); tx_ptr_rst = 1'b1;
    @(negedge clk);
    chk("R9 in_ready low in reset", 64'(in_ready), 64'd0);
    tx_ptr_rst = 1'b0;
    push_byte(8'h01); push_byte(8'h02);
    pulse_launch();
    expect_no_launch("R9 queue emptied by reset");
    @(negedge clk); tx_ptr_rst = 1'b1;
    @(negedge clk); tx_ptr_rst = 1'b0;

    for (int k = 0; k < 6; k++) run_case(VEC[k], 1'b1);

    // R10: leave a response queued, then clear it
    run_case(VEC[0], 1'b0);
    chk("R10 bytes present", 64'(out_valid), 64'd1);
    @(negedge clk); rx_ptr_rst = 1'b1;
    @(negedge clk);
    chk("R10 empty while held", 64'(out_valid), 64'd0);
    rx_ptr_rst = 1'b0;
    @(negedge clk);
    chk("R10 empty after release", 64'(out_valid), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule